// File: doc/BRIEF.md
# Pin Port Data Register Block

This block is the data side of a 16-pin general-purpose I/O port, attached to a simple 32-bit memory-mapped bus with an address, write strobe, write data, read strobe and read data. It keeps an output register whose bits drive the pins, presents the pin levels to software through a read-only register, and offers a write-only word through which individual output bits are set or cleared in a single bus write. Software can therefore change one pin without a read-modify-write sequence that could race another agent touching a neighbouring pin.

Pin inputs pass through a two-flop synchronizer before software sees them. Read data is registered: the value appears on the read data port in the cycle after the read strobe, and is zero in any cycle that follows a cycle without a read. Pin direction, pulls, drive strength and pin multiplexing live elsewhere.

Top module: `pin_port_regs`

## Requirements
- R1: While reset is high and on the cycle after it, `pin_out` is 0x0000 and `bus_rd_data` is 0x00000000.
- R2: A write to offset 0x14 loads `bus_wr_data[15:0]` into the output register (seen on `pin_out` the cycle after); a read of 0x14 returns the output register in bits 15:0 with bits 31:16 zero, and write-data bits 31:16 have no effect.
- R3: A write to offset 0x18 with bit y (y = 0..15) at 1 drives `pin_out[y]` to 1.
- R4: A write to offset 0x18 with bit 16+y at 1 drives `pin_out[y]` to 0.
- R5: In a write to offset 0x18, output bits whose set bit (y) and clear bit (16+y) are both 0 keep their value.
- R6: When bit y and bit 16+y are both 1 in one write to offset 0x18, `pin_out[y]` becomes 1.
- R7: A read of offset 0x18 returns 0x00000000 whatever was written there.
- R8: A read of offset 0x10 returns the pin levels in bits 15:0 and zero in bits 31:16; the value seen is the one `pin_in` had two clock edges before the read is captured, so a read issued in the cycle a pin changes returns the old level and a read issued two cycles later returns the new one.
- R9: Reads of any offset other than 0x10, 0x14 and 0x18 return zero, and writes to them or to offset 0x10 leave `pin_out` unchanged.
- R10: Read data appears one cycle after `bus_rd_en`; it is zero after a cycle with `bus_rd_en` low; a read and a write to offset 0x14 in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data driven to the pins |

## Verification
Two functions meet in one cycle in this block: a read and a write of the output register issued together, and a set and a clear aimed at the same pin within one set/clear word. The bench raises both strobes in one cycle and judges that the read returns the pre-write value while `pin_out` takes the new one, and it writes words with both halves set for the same bits and judges that those pins end at 1 while untouched pins keep their levels. A pin change coinciding with a read of the input register is also provoked and must return the old level.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_IN   = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_BSR  = 2'd3
  } port_sel_e;

endpackage

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
  parameter int PINS   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);

  localparam int WARM_W = $clog2(STAGES + 1);

  logic [PINS-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  // Counts edges since reset so the latency check starts only once the chain is filled.
  logic [WARM_W-1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)                           warm <= '0;
    else if (warm != WARM_W'(STAGES))  warm <= warm + 1'b1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm == WARM_W'(STAGES)) |-> (q == $past(d, STAGES))); // R8

endmodule

// File: rtl/pin_bus_decode.sv
module pin_bus_decode
  import pin_port_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] IN_OFS  = 8'h10,
  parameter logic [ADDR_W-1:0] OUT_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] BSR_OFS = 8'h18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output port_sel_e         sel,
  output logic              load_we,
  output logic              bsr_we
);

  always_comb begin
    if (addr == IN_OFS)       sel = SEL_IN;
    else if (addr == OUT_OFS) sel = SEL_OUT;
    else if (addr == BSR_OFS) sel = SEL_BSR;
    else                      sel = SEL_NONE;
  end

  // Writes to the input register and to unmapped offsets produce no strobe.
  assign load_we = wr_en && (sel == SEL_OUT);
  assign bsr_we  = wr_en && (sel == SEL_BSR);

endmodule

// File: rtl/pin_out_reg.sv
module pin_out_reg #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_we,
  input  logic [PINS-1:0] load_val,
  input  logic            bsr_we,
  input  logic [PINS-1:0] set_val,
  input  logic [PINS-1:0] clr_val,
  output logic [PINS-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load_we) begin
      q <= load_val;
    end else if (bsr_we) begin
      // Clear first, then set: a bit named in both halves ends at 1.
      q <= (q & ~clr_val) | set_val;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_we |=> (q == $past(load_val))); // R2

  AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    (bsr_we && !load_we) |=> ((q & $past(set_val)) == $past(set_val))); // R3

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    (bsr_we && !load_we) |=> ((q & $past(clr_val) & ~$past(set_val)) == '0)); // R4

  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bsr_we && !load_we) |=>
      ((q & ~($past(set_val) | $past(clr_val))) == ($past(q) & ~($past(set_val) | $past(clr_val))))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_we && !bsr_we) |=> $stable(q)); // R9

endmodule

// File: rtl/pin_port_regs.sv
module pin_port_regs
  import pin_port_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] IN_OFS  = 8'h10,
  parameter logic [ADDR_W-1:0] OUT_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] BSR_OFS = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out
);

  localparam int CLR_LSB = DATA_W / 2;

  port_sel_e       sel;
  logic            load_we;
  logic            bsr_we;
  logic [PINS-1:0] in_q;
  logic [DATA_W-1:0] rd_next;

  pin_in_sync #(
    .PINS   (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (in_q)
  );

  pin_bus_decode #(
    .ADDR_W  (ADDR_W),
    .IN_OFS  (IN_OFS),
    .OUT_OFS (OUT_OFS),
    .BSR_OFS (BSR_OFS)
  ) u_dec (
    .addr    (bus_addr),
    .wr_en   (bus_wr_en),
    .sel     (sel),
    .load_we (load_we),
    .bsr_we  (bsr_we)
  );

  pin_out_reg #(
    .PINS (PINS)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_we  (load_we),
    .load_val (bus_wr_data[PINS-1:0]),
    .bsr_we   (bsr_we),
    .set_val  (bus_wr_data[PINS-1:0]),
    .clr_val  (bus_wr_data[CLR_LSB +: PINS]),
    .q        (pin_out)
  );

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_IN:  rd_next[PINS-1:0] = in_q;
      SEL_OUT: rd_next[PINS-1:0] = pin_out;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rd_data <= '0;
    else if (bus_rd_en) bus_rd_data <= rd_next;
    else                bus_rd_data <= '0;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> (bus_rd_data == '0)); // R10

  AST_BSR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == BSR_OFS) |=> (bus_rd_data == '0)); // R7

  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == OUT_OFS) |=> (bus_rd_data[PINS-1:0] == $past(pin_out))); // R10

endmodule

// File: tb/pin_port_regs_test.sv
module pin_port_regs_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wr_data;
  logic        bus_rd_en;
  logic [31:0] bus_rd_data;
  logic [15:0] pin_in;
  logic [15:0] pin_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pin_port_regs uut (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .pin_in      (pin_in),
    .pin_out     (pin_out)
  );

  // {offset, write data, expected pin_out after the write}
  localparam int NVEC = 10;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h14, 32'hFFFF_A5C3, 32'h0000_A5C3},
    {8'h18, 32'h0000_0014, 32'h0000_A5D7},
    {8'h18, 32'h0081_0000, 32'h0000_A556},
    {8'h18, 32'h0000_0000, 32'h0000_A556},
    {8'h18, 32'h0003_0003, 32'h0000_A557},
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_A557},
    {8'h10, 32'h0000_FFFF, 32'h0000_A557},
    {8'h18, 32'hFFFF_0000, 32'h0000_0000},
    {8'h18, 32'h0000_8001, 32'h0000_8001},
    {8'h14, 32'h0000_0000, 32'h0000_0000}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 9:    return "R2";
      1, 8:    return "R3";
      2, 7:    return "R4";
      3:       return "R5";
      4:       return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with strobes dropped.
  task automatic op(input logic [7:0] a, input logic w, input logic [31:0] d, input logic r);
    bus_addr    = a;
    bus_wr_en   = w;
    bus_wr_data = d;
    bus_rd_en   = r;
    @(negedge clk);
    bus_wr_en   = 1'b0;
    bus_rd_en   = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr_en = 1'b0; bus_wr_data = '0; bus_rd_en = 1'b0;
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1", {16'h0, pin_out}, 32'h0);
    check("R1", bus_rd_data, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {16'h0, pin_out}, 32'h0);

    // Vector walk: write, check pins, read the output register back.
    for (int i = 0; i < NVEC; i++) begin
      op(VEC[i][71:64], 1'b1, VEC[i][63:32], 1'b0);
      check(vec_tag(i), {16'h0, pin_out}, VEC[i][31:0]);
      op(8'h14, 1'b0, 32'h0, 1'b1);
      check("R2", bus_rd_data, VEC[i][31:0]);
    end

    // R7: set/clear word reads zero.
    op(8'h14, 1'b1, 32'h0000_1234, 1'b0);
    op(8'h18, 1'b0, 32'h0, 1'b1);
    check("R7", bus_rd_data, 32'h0);

    // R9: unmapped offsets read zero.
    op(8'h1C, 1'b0, 32'h0, 1'b1);
    check("R9", bus_rd_data, 32'h0);
    op(8'h15, 1'b0, 32'h0, 1'b1);
    check("R9", bus_rd_data, 32'h0);

    // R10: read and write of the output register in one cycle.
    op(8'h14, 1'b1, 32'h0000_4321, 1'b1);
    check("R10", bus_rd_data, 32'h0000_1234);
    check("R10", {16'h0, pin_out}, 32'h0000_4321);
    @(negedge clk);
    check("R10", bus_rd_data, 32'h0);

    // R8: input register with two-cycle synchronizer latency.
    pin_in = 16'hBEEF;
    repeat (3) @(negedge clk);
    op(8'h10, 1'b0, 32'h0, 1'b1);
    check("R8", bus_rd_data, 32'h0000_BEEF);
    pin_in = 16'h1357;
    op(8'h10, 1'b0, 32'h0, 1'b1);
    check("R8", bus_rd_data, 32'h0000_BEEF);
    @(negedge clk);
    op(8'h10, 1'b0, 32'h0, 1'b1);
    check("R8", bus_rd_data, 32'h0000_1357);

    // R1: reset in mid-run clears the pins.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", {16'h0, pin_out}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule